// File: doc/BRIEF.md
# I2C Bus Target with 7/10-bit Addressing

This block is a target (slave) on a two-wire I2C bus. It watches the open-drain clock and data lines through synchronisers, finds START and STOP conditions, and decodes its own address. A mode input selects whether the address is 7 or 10 bits wide. When the host writes, each byte is shifted in and then copied into a holding register for the local logic to collect. When the host reads, bytes come from a single transmit register, and the clock line is held low until the local logic has supplied data and given permission to continue.

On the local side the block has plain signals: the own address, the mode bit, transmit data with a load strobe, a release strobe, receive data with a read strobe, flags for a full buffer and an overflow, and a one-cycle event pulse. The two line outputs are pull-down enables. The block only ever pulls a line low or lets it float.

Top module: `i2c_tgt`

## Requirements
- R1: After reset both pull-down enables are 0 and `rx_full`, `rx_ovf`, `stretch` and `dir_tx` are 0.
- R2: In 7-bit mode (`addr10_en`=0) the first byte after a START is address bits 6..0 followed by the R/W bit in bit 0, sent MSB first. The block pulls SDA low in the acknowledge slot only when those seven bits equal `own_addr[6:0]`. After a mismatch it acknowledges nothing until the next START.
- R3: In 10-bit mode the first byte is 11110, then `own_addr[9:8]`, then R/W. A write (R/W=0) is followed by a second byte equal to `own_addr[7:0]`. Each of these bytes is acknowledged only when it matches.
- R4: In 10-bit mode, once a complete two-byte write address has matched, a repeated START followed by only the first byte with R/W=1 is acknowledged and starts a read. After a STOP, that same single byte is not acknowledged.
- R5: Each data byte the block receives while addressed for a write is acknowledged. It appears on `rx_data`, `rx_full` goes to 1, and `evt` is high for exactly one clock.
- R6: If a data byte completes while `rx_full` is 1, the byte is not acknowledged, `rx_ovf` goes to 1 and `rx_data` keeps its old value.
- R7: A one-cycle `rx_read` clears `rx_full` and `rx_ovf` on the next clock.
- R8: After a read address is acknowledged, SCL is held low (`stretch`=1). It is released only after a byte has been loaded with `tx_load` and `rel_set` has been pulsed. The loaded byte is then sent MSB first.
- R9: When the bus host acknowledges a transmitted byte, SCL is held low again for the next byte. When it does not acknowledge, the block releases both lines and drives nothing until the next START.
- R10: A START seen in the middle of a byte abandons that byte, and address matching begins again.
- R11: The SDA pull-down changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr10_en | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | ADDR_W | Address of this target |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Strobe that captures `tx_data` |
| rel_set | input | 1 | Strobe that permits SCL to be released |
| rx_read | input | 1 | Strobe that consumes the received byte |
| rx_data | output | 8 | Last accepted byte |
| rx_full | output | 1 | `rx_data` holds an unread byte |
| rx_ovf | output | 1 | A byte was refused because the buffer was full |
| evt | output | 1 | One-cycle pulse when a byte is accepted |
| stretch | output | 1 | SCL is being held low |
| dir_tx | output | 1 | Block is addressed for a read |

## Verification
Some properties are checked on every cycle: the event pulse lasts one cycle and comes with a full buffer, the overflow flag only rises over a full buffer, held data does not change until it is read, a read strobe empties the buffer, SCL is released only after a release request, SDA is never pulled while SCL is being stretched, and the SDA pull-down only moves while SCL is low. Other behaviour can only be shown by the bench's bus scenarios: which address bytes are acknowledged in each mode, selection by the first byte alone after a repeated START, the refused overflow byte, the byte values sent back, the ending of a read on a NACK, and the aborted byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_ADR1,
        TS_ADR2,
        TS_RX,
        TS_TX
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    // STAGES synchroniser flops plus one history flop per line
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe_d, pipe_q;

        always_comb pipe_d = {pipe_q[STAGES-1:0], raw[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign lvl[g]  = pipe_q[STAGES-1];
        assign rise[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall[g] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/i2c_tgt_rxbuf.sv
module i2c_tgt_rxbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         ovf_set,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         ovf,
    output logic         evt
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         full;
        logic         ovf;
        logic         evt;
    } buf_t;

    buf_t d, q;

    always_comb begin
        d     = q;
        d.evt = 1'b0;
        if (pop) begin
            d.full = 1'b0;
            d.ovf  = 1'b0;
        end
        if (push) begin
            d.data = din;
            d.full = 1'b1;
            d.evt  = 1'b1;
        end
        if (ovf_set) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout = q.data;
    assign full = q.full;
    assign ovf  = q.ovf;
    assign evt  = q.evt;
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              addr10_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [7:0]        tx_data,
    input  logic              tx_load,
    input  logic              rel_set,
    input  logic              rx_read,
    output logic [7:0]        rx_data,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              evt,
    output logic              stretch,
    output logic              dir_tx
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    typedef struct packed {
        tgt_state_e        st;
        tgt_state_e        nxt;
        logic [CNT_W-1:0]  cnt;
        logic              ack_slot;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] tsh;
        logic [BYTE_W-1:0] txreg;
        logic              txfull;
        logic              rel;
        logic              hold;
        logic              sda_oe;
        logic              mack;
        logic              sel10;
    } regs_t;

    regs_t d, q;

    logic [1:0] ln_lvl, ln_rise, ln_fall;
    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic take_ack, rx_push, rx_ovf_set, rw_bit;
    logic [BYTE_W-1:0] tx_src;
    logic rel_pend;

    i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_i, scl_i}),
        .lvl  (ln_lvl),
        .rise (ln_rise),
        .fall (ln_fall)
    );

    assign scl_s     = ln_lvl[0];
    assign sda_s     = ln_lvl[1];
    assign scl_rise  = ln_rise[0];
    assign scl_fall  = ln_fall[0];
    assign bus_start = ln_fall[1] & scl_s;
    assign bus_stop  = ln_rise[1] & scl_s;
    assign rw_bit    = q.shreg[0];

    always_comb begin
        d          = q;
        take_ack   = 1'b0;
        rx_push    = 1'b0;
        rx_ovf_set = 1'b0;
        tx_src     = tx_load ? tx_data : q.txreg;

        if (tx_load) begin
            d.txreg  = tx_data;
            d.txfull = 1'b1;
        end
        if (rel_set) d.rel = 1'b1;

        if (bus_start) begin
            d.st       = TS_ADR1;
            d.cnt      = '0;
            d.ack_slot = 1'b0;
            d.sda_oe   = 1'b0;
            d.hold     = 1'b0;
        end else if (bus_stop) begin
            d.st       = TS_IDLE;
            d.cnt      = '0;
            d.ack_slot = 1'b0;
            d.sda_oe   = 1'b0;
            d.hold     = 1'b0;
            d.sel10    = 1'b0;
        end else begin
            unique case (q.st)
                TS_ADR1, TS_ADR2, TS_RX: begin
                    if (!q.ack_slot) begin
                        if (scl_rise && q.cnt != FULL_CNT) begin
                            d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                            d.cnt   = q.cnt + 1'b1;
                        end else if (scl_fall && q.cnt == FULL_CNT) begin
                            d.ack_slot = 1'b1;
                            d.nxt      = TS_IDLE;
                            if (q.st == TS_ADR1) begin
                                d.sel10 = 1'b0;
                                if (!addr10_en) begin
                                    if (q.shreg[7:1] == own_addr[6:0]) begin
                                        take_ack = 1'b1;
                                        d.nxt    = rw_bit ? TS_TX : TS_RX;
                                    end
                                end else if (q.shreg[7:3] == TEN_BIT_TAG &&
                                             q.shreg[2:1] == own_addr[ADDR_W-1:8]) begin
                                    if (!rw_bit) begin
                                        take_ack = 1'b1;
                                        d.nxt    = TS_ADR2;
                                    end else if (q.sel10) begin
                                        take_ack = 1'b1;
                                        d.sel10  = 1'b1;
                                        d.nxt    = TS_TX;
                                    end
                                end
                            end else if (q.st == TS_ADR2) begin
                                if (q.shreg == own_addr[7:0]) begin
                                    take_ack = 1'b1;
                                    d.sel10  = 1'b1;
                                    d.nxt    = TS_RX;
                                end
                            end else begin
                                d.nxt = TS_RX;
                                if (rx_full) begin
                                    rx_ovf_set = 1'b1;
                                end else begin
                                    rx_push  = 1'b1;
                                    take_ack = 1'b1;
                                end
                            end
                            d.sda_oe = take_ack;
                        end
                    end else if (scl_fall) begin
                        d.ack_slot = 1'b0;
                        d.sda_oe   = 1'b0;
                        d.cnt      = '0;
                        d.st       = q.nxt;
                        if (q.nxt == TS_TX) begin
                            d.hold = 1'b1;
                            d.rel  = 1'b0;
                        end
                    end
                end
                TS_TX: begin
                    if (q.hold) begin
                        if ((q.txfull || tx_load) && (q.rel || rel_set)) begin
                            d.hold   = 1'b0;
                            d.rel    = 1'b0;
                            d.txfull = 1'b0;
                            d.tsh    = tx_src;
                            d.sda_oe = ~tx_src[BYTE_W-1];
                            d.cnt    = '0;
                        end
                    end else if (!q.ack_slot) begin
                        if (scl_fall) begin
                            if (q.cnt == LAST_BIT) begin
                                d.sda_oe   = 1'b0;
                                d.ack_slot = 1'b1;
                            end else begin
                                d.tsh    = {q.tsh[BYTE_W-2:0], 1'b0};
                                d.sda_oe = ~q.tsh[BYTE_W-2];
                                d.cnt    = q.cnt + 1'b1;
                            end
                        end
                    end else begin
                        if (scl_rise) d.mack = ~sda_s;
                        if (scl_fall) begin
                            d.ack_slot = 1'b0;
                            d.cnt      = '0;
                            if (q.mack) begin
                                d.hold = 1'b1;
                                d.rel  = 1'b0;
                            end else begin
                                d.st = TS_IDLE;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= TS_IDLE;
            q.nxt <= TS_IDLE;
        end else begin
            q <= d;
        end
    end

    i2c_tgt_rxbuf #(.W(BYTE_W)) u_rxbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (rx_push),
        .ovf_set(rx_ovf_set),
        .pop    (rx_read),
        .din    (q.shreg),
        .dout   (rx_data),
        .full   (rx_full),
        .ovf    (rx_ovf),
        .evt    (evt)
    );

    assign scl_oe   = q.hold;
    assign sda_oe   = q.sda_oe;
    assign stretch  = q.hold;
    assign dir_tx   = (q.st == TS_TX);
    assign rel_pend = q.rel;
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt,
    input logic       rx_full,
    input logic       rx_ovf,
    input logic       rx_read,
    input logic [7:0] rx_data,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       rel_set,
    input logic       rel_pend,
    input logic       scl_s
);
    assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    assert_evt_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> rx_full);

    assert_ovf_over_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> $past(rx_full));

    assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_read) |=> $stable(rx_data));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_read |=> !rx_full);

    assert_release_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> $past(rel_pend || rel_set));

    assert_sda_quiet_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !sda_oe);

    assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .rx_full (rx_full),
    .rx_ovf  (rx_ovf),
    .rx_read (rx_read),
    .rx_data (rx_data),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .rel_set (rel_set),
    .rel_pend(rel_pend),
    .scl_s   (scl_s)
);

// File: tb/i2c_tgt_bench.sv
module i2c_tgt_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 9;

    // {mode10, own[9:0], first byte, second byte, expect ack1, expect ack2}
    localparam logic [28:0] VECS [NVEC] = '{
        {1'b0, 10'h05A, 8'hB4, 8'h00, 1'b1, 1'b0},
        {1'b0, 10'h05A, 8'hB6, 8'h00, 1'b0, 1'b0},
        {1'b0, 10'h03C, 8'h78, 8'h00, 1'b1, 1'b0},
        {1'b0, 10'h05A, 8'hF4, 8'h00, 1'b0, 1'b0},
        {1'b1, 10'h2A5, 8'hF4, 8'hA5, 1'b1, 1'b1},
        {1'b1, 10'h2A5, 8'hF4, 8'hA4, 1'b1, 1'b0},
        {1'b1, 10'h2A5, 8'hF6, 8'hA5, 1'b0, 1'b0},
        {1'b1, 10'h1F0, 8'hF2, 8'hF0, 1'b1, 1'b1},
        {1'b1, 10'h2A5, 8'hF5, 8'h00, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl, sda;
    logic scl_oe, sda_oe;
    logic addr10_en = 1'b0;
    logic [9:0] own_addr = '0;
    logic [7:0] tx_data = '0;
    logic tx_load = 1'b0, rel_set = 1'b0, rx_read = 1'b0;
    logic [7:0] rx_data;
    logic rx_full, rx_ovf, evt, stretch, dir_tx;

    int n_chk = 0;
    int n_bad = 0;
    int evt_seen = 0;
    int sda_bad = 0;
    logic sda_oe_prev = 1'b0, scl_prev = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl = scl_m & ~scl_oe;
    assign sda = sda_m & ~sda_oe;

    i2c_tgt u_i2c_tgt (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .addr10_en(addr10_en),
        .own_addr(own_addr), .tx_data(tx_data), .tx_load(tx_load),
        .rel_set(rel_set), .rx_read(rx_read), .rx_data(rx_data),
        .rx_full(rx_full), .rx_ovf(rx_ovf), .evt(evt),
        .stretch(stretch), .dir_tx(dir_tx)
    );

    always @(negedge clk) begin
        if (evt) evt_seen++;
        if (rst_n && sda_oe != sda_oe_prev && scl_prev) sda_bad++;
        sda_oe_prev = sda_oe;
        scl_prev    = scl;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic s);
        sda_m = b;
        hw(Q);
        scl_m = 1'b1;
        while (scl !== 1'b1) @(negedge clk);
        hw(Q);
        s = sda;
        hw(1);
        scl_m = 1'b0;
        hw(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        hw(Q);
        scl_m = 1'b1;
        while (scl !== 1'b1) @(negedge clk);
        hw(Q);
        sda_m = 1'b0;
        hw(Q);
        scl_m = 1'b0;
        hw(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        hw(Q);
        scl_m = 1'b1;
        while (scl !== 1'b1) @(negedge clk);
        hw(Q);
        sda_m = 1'b1;
        hw(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            v[i] = s;
        end
        bit_cycle(nack, s);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int e0;

        hw(5);
        // R1 reset state
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 rx_full", rx_full, 0);
        check("R1 rx_ovf", rx_ovf, 0);
        check("R1 stretch", stretch, 0);
        check("R1 dir_tx", dir_tx, 0);
        rst_n = 1'b1;
        hw(5);

        // Address table (R2, R3, R4)
        for (int i = 0; i < NVEC; i++) begin
            addr10_en = VECS[i][28];
            own_addr  = VECS[i][27:18];
            bus_start();
            send_byte(VECS[i][17:10], ack);
            check(VECS[i][28] ? "R3 first address byte" : "R2 address byte", ack, VECS[i][1]);
            if (VECS[i][28] && !VECS[i][10]) begin
                send_byte(VECS[i][9:2], ack);
                check("R3 second address byte", ack, VECS[i][0]);
            end
            bus_stop();
        end

        // R2: after a mismatch nothing is acknowledged until START
        addr10_en = 1'b0;
        own_addr  = 10'h05A;
        bus_start();
        send_byte(8'hB6, ack);
        send_byte(8'hB4, ack);
        check("R2 ignored after mismatch", ack, 0);
        bus_stop();

        // R5 write one byte
        e0 = evt_seen;
        bus_start();
        send_byte(8'hB4, ack);
        send_byte(8'hC3, ack);
        check("R5 data ack", ack, 1);
        check("R5 rx_data", rx_data, 8'hC3);
        check("R5 rx_full", rx_full, 1);
        check("R5 single evt", evt_seen - e0, 1);

        // R6 overflow
        send_byte(8'h11, ack);
        check("R6 overflow nack", ack, 0);
        check("R6 rx_ovf", rx_ovf, 1);
        check("R6 data kept", rx_data, 8'hC3);
        check("R6 no evt", evt_seen - e0, 1);
        bus_stop();

        // R7 read strobe
        rx_read = 1'b1;
        hw(1);
        rx_read = 1'b0;
        hw(1);
        check("R7 rx_full cleared", rx_full, 0);
        check("R7 rx_ovf cleared", rx_ovf, 0);

        // R3/R4/R8/R9: 10-bit write, restart, read
        addr10_en = 1'b1;
        own_addr  = 10'h2A5;
        bus_start();
        send_byte(8'hF4, ack);
        check("R3 hi byte", ack, 1);
        send_byte(8'hA5, ack);
        check("R3 lo byte", ack, 1);
        send_byte(8'h96, ack);
        check("R5 10-bit data", rx_data, 8'h96);
        bus_start();
        send_byte(8'hF5, ack);
        check("R4 restart read ack", ack, 1);
        hw(4);
        check("R8 stretch after read addr", stretch, 1);
        check("R8 dir_tx", dir_tx, 1);
        tx_data = 8'hA7;
        tx_load = 1'b1;
        hw(1);
        tx_load = 1'b0;
        hw(30);
        check("R8 held without release", stretch, 1);
        rel_set = 1'b1;
        hw(1);
        rel_set = 1'b0;
        hw(4);
        check("R8 released", stretch, 0);
        recv_byte(1'b0, v);
        check("R8 first byte sent", v, 8'hA7);
        hw(4);
        check("R9 stretch after master ack", stretch, 1);
        tx_data = 8'h3C;
        tx_load = 1'b1;
        rel_set = 1'b1;
        hw(1);
        tx_load = 1'b0;
        rel_set = 1'b0;
        recv_byte(1'b1, v);
        check("R8 second byte sent", v, 8'h3C);
        hw(4);
        check("R9 no stretch after nack", stretch, 0);
        check("R9 sda released after nack", sda_oe, 0);
        recv_byte(1'b1, v);
        check("R9 silent after nack", v, 8'hFF);
        bus_stop();
        rx_read = 1'b1;
        hw(1);
        rx_read = 1'b0;

        // R4: after STOP the single first byte is refused
        bus_start();
        send_byte(8'hF5, ack);
        check("R4 read refused after stop", ack, 0);
        bus_stop();

        // R10: START in mid-byte aborts
        addr10_en = 1'b0;
        own_addr  = 10'h05A;
        bus_start();
        bit_cycle(1'b1, ack);
        bit_cycle(1'b0, ack);
        bit_cycle(1'b1, ack);
        bus_start();
        send_byte(8'hB4, ack);
        check("R10 address after abort", ack, 1);
        send_byte(8'h5E, ack);
        check("R10 data after abort", rx_data, 8'h5E);
        bus_stop();

        // R11: SDA pull-down only moved with SCL low
        check("R11 sda changes with scl low", sda_bad, 0);

        summary();
        $finish;
    end
endmodule